// File: doc/BRIEF.md
# Receive Frame Acquisition Controller

This block is the control unit of a packet receiver. While the receiver is quiet it waits on a signal-strength detect input. When that detect fires it starts an acquisition window in which the synchronization blocks are enabled. If the start-of-frame strobe does not arrive before a parameterised timeout, the window is abandoned, a one-cycle timeout pulse is raised and the block returns to waiting. The start-of-frame strobe marks the end of the short training field.

After start of frame the controller enables the transform and decode stage and keeps synchronization tracking running. It then walks the remaining fields in order: a long training field of fixed length, a header field that lasts until the header decoder reports a result, and a data field. The data field's length is taken from the decoded header at run time: the symbol count times the cycles per symbol. When exactly that many active data cycles have passed, the controller raises a one-cycle frame stop and goes back to waiting. A failed header decode aborts the frame.

Block-level reconfiguration may be requested at any point after start of frame. While it runs, the transform stage is held off and the field timers are frozen, but synchronization tracking stays enabled. The correlation, transform and header-decoding datapaths are outside this block and appear only as strobes and a length input.

Top module: `rx_frame_ctrl`

## Requirements
- R1: After reset, `rxState` is 0 and every enable, field indicator and pulse output is low.
- R2: `rxState` encodes waiting as 0, acquisition as 1 and post-start-of-frame as 2. A high `rssiDetect` while waiting moves the block to acquisition on the next cycle. `rssiDetect` is ignored in any other state. `syncEn` is high exactly while in acquisition.
- R3: Without a start-of-frame strobe, acquisition lasts exactly `TIMEOUT_CYCLES` cycles. The block then returns to waiting, and `timeoutPulse` is high for exactly the first waiting cycle.
- R4: A `sofStrobe` during acquisition moves the block to post-start-of-frame with `fieldLtf` set, even on the last cycle before timeout. A `sofStrobe` while waiting is ignored.
- R5: `fieldLtf` stays high for exactly `LTF_CYCLES` cycles in which no reconfiguration is active. `fieldHdr` follows it.
- R6: A `hdrValid` during the header field sets N = `hdrLen` × `CYC_PER_SYM`. `fieldData` then stays high for exactly N cycles in which no reconfiguration is active. After that the block returns to waiting, with `frameStop` high for one cycle. If N is 0, the return and the stop pulse come straight from the header field. Header strobes outside the header field are ignored.
- R7: A `hdrInvalid` during the header field returns the block to waiting without `frameStop`. If both header strobes arrive together, the invalid strobe wins.
- R8: `trackEn` is high exactly in post-start-of-frame. At most one field indicator is high, and only in that state.
- R9: A `reconfReq` in post-start-of-frame sets `reconfActive` from the next cycle until the cycle after `reconfDone`. While it is set, `xformEn` is low, `trackEn` stays high, the field timers hold and header strobes are ignored. `reconfReq` outside post-start-of-frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rssiDetect | input | 1 | Incoming-signal detect from the power estimator |
| sofStrobe | input | 1 | Start-of-frame found by the synchronizer |
| hdrValid | input | 1 | Header decoded correctly, `hdrLen` valid |
| hdrInvalid | input | 1 | Header decode failed |
| hdrLen | input | LEN_W | Data field length in symbols |
| reconfReq | input | 1 | Request block-level reconfiguration |
| reconfDone | input | 1 | Reconfiguration finished |
| rxState | output | 2 | 0 waiting, 1 acquisition, 2 post-start-of-frame |
| syncEn | output | 1 | Enable for the synchronization blocks |
| trackEn | output | 1 | Enable for synchronization tracking |
| xformEn | output | 1 | Enable for the transform and decode stage |
| fieldLtf | output | 1 | Long training field in progress |
| fieldHdr | output | 1 | Header field in progress |
| fieldData | output | 1 | Data field in progress |
| reconfActive | output | 1 | Reconfiguration in progress |
| frameStop | output | 1 | One-cycle pulse at the end of the data field |
| timeoutPulse | output | 1 | One-cycle pulse when acquisition times out |

## Verification
On every cycle, the embedded properties check the following:
- a timeout pulse only ever follows acquisition;
- a frame stop only ever follows the header or data field;
- field indicators appear only after start of frame;
- the long training field begins only from a start-of-frame strobe;
- the field state does not move while reconfiguration holds;
- no field timer decrements past zero.

Only the bench scenarios can show the exact lengths: the timeout window, the long training field, and the data field measured against random header lengths with reconfiguration stalls inserted. The same applies to the strobes that must be ignored in the wrong state, and to the priority of start of frame over timeout on the final cycle.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_ACQ  = 2'd1,
    RX_POST = 2'd2
  } rxTop_e;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_LTF  = 2'd1,
    FLD_HDR  = 2'd2,
    FLD_DATA = 2'd3
  } rxField_e;

  // strobes from the control FSM to the field timers
  typedef struct packed {
    logic toLoad;
    logic toDec;
    logic ltfLoad;
    logic ltfDec;
    logic dataLoad;
    logic dataDec;
  } timerCtl_t;

  // terminal flags from the field timers back to the FSM
  typedef struct packed {
    logic toLast;
    logic ltfLast;
    logic dataLast;
    logic lenZero;
  } timerSts_t;

endpackage

// File: rtl/rx_down_counter.sv
module rx_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= loadVal;
    else if (dec)    cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);

  // R6: the FSM must stop a timer at its terminal count, never wrap it
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/rx_field_timers.sv
module rx_field_timers
  import rx_frame_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40,
  parameter int LTF_CYCLES     = 32,
  parameter int LEN_W          = 8,
  parameter int CYC_PER_SYM    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timerCtl_t        ctl,
  input  logic [LEN_W-1:0] hdrLen,
  output timerSts_t        sts
);

  localparam int TO_W   = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int LTF_W  = (LTF_CYCLES > 1) ? $clog2(LTF_CYCLES) : 1;
  localparam int DATA_W = LEN_W + $clog2(CYC_PER_SYM + 1);

  logic [DATA_W-1:0] dataCycles;

  assign dataCycles  = DATA_W'(hdrLen) * DATA_W'(CYC_PER_SYM);
  assign sts.lenZero = (dataCycles == '0);

  rx_down_counter #(.W(TO_W)) u_toCnt (
    .clk(clk), .rst_n(rst_n),
    .load(ctl.toLoad), .loadVal(TO_W'(TIMEOUT_CYCLES - 1)),
    .dec(ctl.toDec), .last(sts.toLast)
  );

  rx_down_counter #(.W(LTF_W)) u_ltfCnt (
    .clk(clk), .rst_n(rst_n),
    .load(ctl.ltfLoad), .loadVal(LTF_W'(LTF_CYCLES - 1)),
    .dec(ctl.ltfDec), .last(sts.ltfLast)
  );

  rx_down_counter #(.W(DATA_W)) u_dataCnt (
    .clk(clk), .rst_n(rst_n),
    .load(ctl.dataLoad), .loadVal(dataCycles - DATA_W'(1)),
    .dec(ctl.dataDec), .last(sts.dataLast)
  );

endmodule

// File: rtl/rx_ctrl_fsm.sv
module rx_ctrl_fsm
  import rx_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rssiDetect,
  input  logic       sofStrobe,
  input  logic       hdrValid,
  input  logic       hdrInvalid,
  input  logic       reconfReq,
  input  logic       reconfDone,
  input  timerSts_t  sts,
  output timerCtl_t  ctl,
  output logic [1:0] rxState,
  output logic       syncEn,
  output logic       trackEn,
  output logic       xformEn,
  output logic       fieldLtf,
  output logic       fieldHdr,
  output logic       fieldData,
  output logic       reconfActive,
  output logic       frameStop,
  output logic       timeoutPulse
);

  rxTop_e   state, stateNext;
  rxField_e field, fieldNext;
  logic     rcActive, rcNext;
  logic     stopNext, toNext;

  always_comb begin
    stateNext = state;
    fieldNext = field;
    stopNext  = 1'b0;
    toNext    = 1'b0;
    ctl       = '0;
    unique case (state)
      RX_WAIT: begin
        if (rssiDetect) begin
          stateNext  = RX_ACQ;
          ctl.toLoad = 1'b1;
        end
      end
      RX_ACQ: begin
        if (sofStrobe) begin
          stateNext   = RX_POST;
          fieldNext   = FLD_LTF;
          ctl.ltfLoad = 1'b1;
        end else if (sts.toLast) begin
          stateNext = RX_WAIT;
          toNext    = 1'b1;
        end else begin
          ctl.toDec = 1'b1;
        end
      end
      RX_POST: begin
        if (!rcActive) begin
          unique case (field)
            FLD_LTF: begin
              if (sts.ltfLast) fieldNext  = FLD_HDR;
              else             ctl.ltfDec = 1'b1;
            end
            FLD_HDR: begin
              if (hdrInvalid) begin
                stateNext = RX_WAIT;
                fieldNext = FLD_NONE;
              end else if (hdrValid) begin
                if (sts.lenZero) begin
                  stateNext = RX_WAIT;
                  fieldNext = FLD_NONE;
                  stopNext  = 1'b1;
                end else begin
                  fieldNext    = FLD_DATA;
                  ctl.dataLoad = 1'b1;
                end
              end
            end
            FLD_DATA: begin
              if (sts.dataLast) begin
                stateNext = RX_WAIT;
                fieldNext = FLD_NONE;
                stopNext  = 1'b1;
              end else begin
                ctl.dataDec = 1'b1;
              end
            end
            default: fieldNext = FLD_NONE;
          endcase
        end
      end
      default: begin
        stateNext = RX_WAIT;
        fieldNext = FLD_NONE;
      end
    endcase
  end

  always_comb begin
    rcNext = rcActive;
    if (rcActive && reconfDone)                     rcNext = 1'b0;
    else if (!rcActive && reconfReq && state == RX_POST) rcNext = 1'b1;
    if (stateNext != RX_POST)                       rcNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RX_WAIT;
      field        <= FLD_NONE;
      rcActive     <= 1'b0;
      frameStop    <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      field        <= fieldNext;
      rcActive     <= rcNext;
      frameStop    <= stopNext;
      timeoutPulse <= toNext;
    end
  end

  assign rxState      = state;
  assign syncEn       = (state == RX_ACQ);
  assign trackEn      = (state == RX_POST);
  assign xformEn      = (state == RX_POST) && !rcActive;
  assign fieldLtf     = (field == FLD_LTF);
  assign fieldHdr     = (field == FLD_HDR);
  assign fieldData    = (field == FLD_DATA);
  assign reconfActive = rcActive;

  // R3: a timeout report only ever closes an acquisition window
  assert_timeout_after_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutPulse |-> (state == RX_WAIT && $past(state) == RX_ACQ));

  // R6: a frame stop only ever closes the header or data field
  assert_stop_after_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameStop |-> (state == RX_WAIT && ($past(field) == FLD_HDR || $past(field) == FLD_DATA)));

  // R8: field activity is confined to the post-start-of-frame state
  assert_fields_only_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fieldLtf || fieldHdr || fieldData) |-> (state == RX_POST));

  // R4: the long training field is entered only through a start-of-frame strobe
  assert_ltf_from_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fieldLtf) |-> ($past(state) == RX_ACQ && $past(sofStrobe)));

  // R9: an ongoing reconfiguration freezes the field sequence
  assert_reconf_holds_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rcActive && !reconfDone) |=> $stable(field));

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40,
  parameter int LTF_CYCLES     = 32,
  parameter int LEN_W          = 8,
  parameter int CYC_PER_SYM    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rssiDetect,
  input  logic             sofStrobe,
  input  logic             hdrValid,
  input  logic             hdrInvalid,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             reconfReq,
  input  logic             reconfDone,
  output logic [1:0]       rxState,
  output logic             syncEn,
  output logic             trackEn,
  output logic             xformEn,
  output logic             fieldLtf,
  output logic             fieldHdr,
  output logic             fieldData,
  output logic             reconfActive,
  output logic             frameStop,
  output logic             timeoutPulse
);

  timerCtl_t timerCtl;
  timerSts_t timerSts;

  rx_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .rssiDetect(rssiDetect), .sofStrobe(sofStrobe),
    .hdrValid(hdrValid), .hdrInvalid(hdrInvalid),
    .reconfReq(reconfReq), .reconfDone(reconfDone),
    .sts(timerSts), .ctl(timerCtl),
    .rxState(rxState), .syncEn(syncEn), .trackEn(trackEn), .xformEn(xformEn),
    .fieldLtf(fieldLtf), .fieldHdr(fieldHdr), .fieldData(fieldData),
    .reconfActive(reconfActive), .frameStop(frameStop), .timeoutPulse(timeoutPulse)
  );

  rx_field_timers #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LTF_CYCLES(LTF_CYCLES),
    .LEN_W(LEN_W), .CYC_PER_SYM(CYC_PER_SYM)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .ctl(timerCtl), .hdrLen(hdrLen), .sts(timerSts)
  );

endmodule

// File: tb/rx_frame_ctrl_tb.sv
`timescale 1ns/1ps
module rx_frame_ctrl_tb;

  localparam int TO  = 40;
  localparam int LTF = 32;
  localparam int LW  = 8;
  localparam int CPS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rssiDetect = 0, sofStrobe = 0, hdrValid = 0, hdrInvalid = 0;
  logic [LW-1:0] hdrLen = '0;
  logic reconfReq = 0, reconfDone = 0;
  logic [1:0] rxState;
  logic syncEn, trackEn, xformEn, fieldLtf, fieldHdr, fieldData;
  logic reconfActive, frameStop, timeoutPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_frame_ctrl #(.TIMEOUT_CYCLES(TO), .LTF_CYCLES(LTF), .LEN_W(LW), .CYC_PER_SYM(CPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rssiDetect(rssiDetect), .sofStrobe(sofStrobe),
    .hdrValid(hdrValid), .hdrInvalid(hdrInvalid), .hdrLen(hdrLen),
    .reconfReq(reconfReq), .reconfDone(reconfDone),
    .rxState(rxState), .syncEn(syncEn), .trackEn(trackEn), .xformEn(xformEn),
    .fieldLtf(fieldLtf), .fieldHdr(fieldHdr), .fieldData(fieldData),
    .reconfActive(reconfActive), .frameStop(frameStop), .timeoutPulse(timeoutPulse)
  );

  function automatic int expDataCycles(int len);
    return len * CPS;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic startAcq();
    rssiDetect = 1; tick(); rssiDetect = 0;
    chk("R2 enter acquisition", rxState, 1);
    chk("R2 syncEn in acquisition", syncEn, 1);
  endtask

  task automatic runFrame(int preDelay, int len, bit doReconf, int rcLen);
    int cnt, unst, cyc, rcCnt;
    startAcq();
    repeat (preDelay) tick();
    sofStrobe = 1; tick(); sofStrobe = 0;
    chk("R4 post after sof", rxState, 2);
    chk("R4 fieldLtf after sof", fieldLtf, 1);
    chk("R8 trackEn in post", trackEn, 1);
    cnt = 0;
    while (fieldLtf && cnt < 1000) begin
      cnt++;
      hdrLen = '0;
      hdrValid = (cnt == 2);  // R6: header strobe outside header field ignored
      tick();
    end
    hdrValid = 0;
    chk("R5 ltf length", cnt, LTF);
    chk("R5 header follows ltf", fieldHdr, 1);
    rssiDetect = 1; tick(); rssiDetect = 0;
    chk("R2 rssi ignored in post", fieldHdr, 1);
    hdrLen = LW'(len); hdrValid = 1; tick(); hdrValid = 0;
    if (expDataCycles(len) == 0) begin
      chk("R6 zero length stops at header", frameStop, 1);
      chk("R6 zero length to wait", rxState, 0);
    end else begin
      unst = 0; cyc = 0; rcCnt = 0;
      while (fieldData && cyc < 5000) begin
        chk("R8 single field", {fieldLtf, fieldHdr}, 0);
        if (!reconfActive) unst++;
        reconfReq = doReconf && (cyc == 1);
        if (reconfActive) begin
          rcCnt++;
          chk("R9 xform held", xformEn, 0);
          chk("R9 tracking kept", trackEn, 1);
        end
        reconfDone = reconfActive && (rcCnt == rcLen);
        cyc++;
        tick();
      end
      reconfReq = 0; reconfDone = 0;
      chk("R6 data length", unst, expDataCycles(len));
      chk("R6 frame stop", frameStop, 1);
      chk("R6 back to wait", rxState, 0);
      if (doReconf && expDataCycles(len) >= 3)
        chk("R9 reconf cycles observed", rcCnt, rcLen);
    end
    tick();
    chk("R6 stop is one cycle", frameStop, 0);
    chk("R9 reconf cleared", reconfActive, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_0042));
    #1;
    chk("R1 reset state", rxState, 0);
    chk("R1 reset outputs", {syncEn, trackEn, xformEn, fieldLtf, fieldHdr, fieldData,
                             reconfActive, frameStop, timeoutPulse}, 0);
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 idle after reset", rxState, 0);

    // R4: sof while waiting ignored; R9: reconf request while waiting ignored
    sofStrobe = 1; reconfReq = 1; tick(); sofStrobe = 0; reconfReq = 0;
    chk("R4 sof ignored in wait", rxState, 0);
    chk("R9 reconf ignored in wait", reconfActive, 0);

    // R3: timeout window
    startAcq();
    cnt = 1; tick();
    while (rxState == 1 && cnt < 1000) begin cnt++; tick(); end
    chk("R3 acquisition length", cnt, TO);
    chk("R3 timeout pulse", timeoutPulse, 1);
    chk("R3 back to wait", rxState, 0);
    chk("R2 syncEn off in wait", syncEn, 0);
    tick();
    chk("R3 timeout pulse one cycle", timeoutPulse, 0);

    // R4: sof on the very last acquisition cycle wins
    startAcq();
    repeat (TO - 1) tick();
    chk("R4 still acquiring on last cycle", rxState, 1);
    sofStrobe = 1; tick(); sofStrobe = 0;
    chk("R4 sof beats timeout", rxState, 2);
    chk("R4 no timeout pulse", timeoutPulse, 0);
    repeat (LTF) tick();
    chk("R5 header after ltf", fieldHdr, 1);
    // R9: reconf during header, strobes ignored
    reconfReq = 1; tick(); reconfReq = 0;
    chk("R9 reconf active", reconfActive, 1);
    hdrInvalid = 1; tick();
    chk("R9 header strobe ignored in reconf", fieldHdr, 1);
    chk("R9 still post", rxState, 2);
    reconfDone = 1; hdrInvalid = 0; tick(); reconfDone = 0;
    chk("R9 reconf done", reconfActive, 0);
    // R7: invalid beats valid
    hdrLen = 8'd5; hdrValid = 1; hdrInvalid = 1; tick(); hdrValid = 0; hdrInvalid = 0;
    chk("R7 abort to wait", rxState, 0);
    chk("R7 no frame stop", frameStop, 0);
    chk("R7 no data field", fieldData, 0);

    // directed corners then random frames
    runFrame(0, 0, 0, 1);
    runFrame(3, 1, 0, 1);
    runFrame(5, 255, 1, 4);
    for (int i = 0; i < 14; i++) begin
      runFrame($urandom_range(0, TO - 2), $urandom_range(0, 40),
               1'($urandom_range(0, 1)), $urandom_range(1, 6));
      repeat ($urandom_range(0, 3)) tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule